// File: doc/BRIEF.md
# Reloadable Timer and Event Counter Channel

This block is one counter channel with a reload register. In timer mode it counts down by one on each cycle of a prescaled tick strobe. In event mode it counts one of two external event strobes, chosen by a select bit, and counts up or down. A count that passes below zero, or past all-ones when counting up, loads the reload value again. That cycle raises a one-cycle flag and toggles a pulse output.

Software reaches the channel through a small word bus. It can set the start and cutoff bits, set the mode while the channel is stopped, write the reload value and read the live count at any time. The read path returns fixed marker values in the cycle of a wrap, so software can never see a half-updated count. An active-low emergency input, gated by the cutoff enable bit, turns off the pulse output's output enable without waiting for a clock.

All count sources are single-cycle strobes sampled on the block clock. The channel is fully synchronous apart from the cutoff path.

Top module: `rtmr_channel`

## Requirements
- R1: After reset, every register reads zero: the count, the control register, the mode register and the reload value. `uflow`, `oflow` and `pulse_out` are low, and `pulse_oe` is high.
- R2: The mode register is at address 1: bit 0 selects the mode (0 timer, 1 event), bit 1 selects up counting, bit 2 selects `evt_b` as the event source. A write to it while the start bit is 1 is ignored, and the register reads back unchanged.
- R3: In timer mode with start set, each cycle with `tick_en` high lowers the count by one. The event strobes and the up bit have no effect.
- R4: When counting down, a step at count 0 loads the reload value. `uflow` is then high for the next cycle. A count read in the step cycle returns 16'hFFFF.
- R5: When counting up in event mode, a step at 16'hFFFF loads the reload value. `oflow` is then high for the next cycle. A count read in the step cycle returns 16'h0000.
- R6: In event mode only the selected strobe counts (`evt_a` when mode bit 2 is 0, `evt_b` when it is 1). The other strobe leaves the count unchanged.
- R7: The count/reload register is at address 2. Writing it while stopped sets both the reload value and the count, so the written value reads back before counting starts. Writing it while running changes only the reload value, which is used at the next wrap.
- R8: `pulse_out` toggles in the cycle after each underflow or overflow.
- R9: `pulse_oe` is low exactly while the cutoff enable bit is 1 and `emerg_n` is low. It follows `emerg_n` with no clock delay.
- R10: While the start bit is 0, no strobe changes the count.
- R11: The control register is at address 0: bit 0 is start, bit 1 is cutoff enable. It is writable at any time and reads back.
- R12: `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (combinational data) |
| bus_addr | input | 2 | Register address: 0 control, 1 mode, 2 count/reload |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not reading |
| tick_en | input | 1 | Prescaled tick strobe for timer mode |
| evt_a | input | 1 | Event strobe A |
| evt_b | input | 1 | Event strobe B |
| emerg_n | input | 1 | Active-low emergency cutoff input |
| uflow | output | 1 | One-cycle underflow flag |
| oflow | output | 1 | One-cycle overflow flag |
| pulse_out | output | 1 | Output that toggles on each wrap |
| pulse_oe | output | 1 | Output enable for `pulse_out`, low during cutoff |

## Verification
Two things can fall in the same cycle: a software read of the count, and a count step that wraps the counter. In that cycle the read must return a marker value instead of the register contents. The bench provokes this by raising the read strobe and the counting strobe together at count 0 (counting down) and at all-ones (counting up). It expects 16'hFFFF and 16'h0000 respectively. It then checks the reloaded count, the flag and the pulse toggle in the following cycle. A reload write while running is placed just before a wrap, so the bench can judge that the new value is used at that wrap and not before.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;

  typedef enum logic {
    MODE_TIMER = 1'b0,
    MODE_EVENT = 1'b1
  } rtmr_mode_e;

  // bit 0 mode, bit 1 up, bit 2 event source B
  typedef struct packed {
    logic       trig_b;
    logic       dir_up;
    rtmr_mode_e mode;
  } rtmr_cfg_t;

  localparam int CFG_W    = 3;
  localparam int CTRL_W   = 2;
  localparam int ADR_CTRL = 0;
  localparam int ADR_MODE = 1;
  localparam int ADR_CNT  = 2;

endpackage

// File: rtl/rtmr_regs.sv
module rtmr_regs
  import rtmr_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  input  logic [CW-1:0] cnt_q,
  input  logic          ev_uflow,
  input  logic          ev_oflow,
  output logic          start_q,
  output logic          cut_en_q,
  output rtmr_cfg_t     cfg_q,
  output logic [CW-1:0] reload_q,
  output logic          ld_stop,
  output logic [CW-1:0] bus_rdata
);

  logic sel_ctrl, sel_mode, sel_cnt;

  assign sel_ctrl = (bus_addr == AW'(ADR_CTRL));
  assign sel_mode = (bus_addr == AW'(ADR_MODE));
  assign sel_cnt  = (bus_addr == AW'(ADR_CNT));

  // a reload write while stopped also presets the count
  assign ld_stop = bus_wr && sel_cnt && !start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      cut_en_q <= 1'b0;
      cfg_q    <= '0;
      reload_q <= '0;
    end else if (bus_wr) begin
      if (sel_ctrl) begin
        start_q  <= bus_wdata[0];
        cut_en_q <= bus_wdata[1];
      end
      if (sel_mode && !start_q) begin
        cfg_q <= rtmr_cfg_t'(bus_wdata[CFG_W-1:0]);
      end
      if (sel_cnt) begin
        reload_q <= bus_wdata;
      end
    end
  end

  function automatic logic [CW-1:0] f_count_view(
    input logic [CW-1:0] cnt,
    input logic          uf,
    input logic          of
  );
    if (of)      return '0;
    else if (uf) return '1;
    else         return cnt;
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_ctrl)      bus_rdata = {{(CW-CTRL_W){1'b0}}, cut_en_q, start_q};
      else if (sel_mode) bus_rdata = {{(CW-CFG_W){1'b0}}, cfg_q};
      else if (sel_cnt)  bus_rdata = f_count_view(cnt_q, ev_uflow, ev_oflow);
    end
  end

endmodule

// File: rtl/rtmr_core.sv
module rtmr_core
  import rtmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  rtmr_cfg_t     cfg,
  input  logic [CW-1:0] reload,
  input  logic          ld_stop,
  input  logic [CW-1:0] ld_val,
  input  logic          tick_en,
  input  logic          evt_a,
  input  logic          evt_b,
  output logic [CW-1:0] cnt_q,
  output logic          step,
  output logic          ev_uflow,
  output logic          ev_oflow,
  output logic          uflow_q,
  output logic          oflow_q
);

  logic going_up;
  logic src;

  function automatic logic f_at_floor(input logic [CW-1:0] c);
    return (c == '0);
  endfunction

  function automatic logic f_at_ceil(input logic [CW-1:0] c);
    return (&c);
  endfunction

  function automatic logic [CW-1:0] f_next(input logic [CW-1:0] c, input logic up);
    return up ? (c + CW'(1)) : (c - CW'(1));
  endfunction

  assign going_up = (cfg.mode == MODE_EVENT) && cfg.dir_up;

  always_comb begin
    if (cfg.mode == MODE_TIMER) src = tick_en;
    else                        src = cfg.trig_b ? evt_b : evt_a;
  end

  assign step     = start && src;
  assign ev_uflow = step && !going_up && f_at_floor(cnt_q);
  assign ev_oflow = step &&  going_up && f_at_ceil(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      uflow_q <= 1'b0;
      oflow_q <= 1'b0;
    end else begin
      uflow_q <= ev_uflow;
      oflow_q <= ev_oflow;
      if (ld_stop)                    cnt_q <= ld_val;
      else if (ev_uflow || ev_oflow)  cnt_q <= reload;
      else if (step)                  cnt_q <= f_next(cnt_q, going_up);
    end
  end

endmodule

// File: rtl/rtmr_outctl.sv
module rtmr_outctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic cut_en,
  input  logic emerg_n,
  output logic pulse_q,
  output logic oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pulse_q <= 1'b0;
    else if (wrap) pulse_q <= ~pulse_q;
  end

  // cutoff path is purely combinational so it acts without a clock
  assign oe = !(cut_en && !emerg_n);

endmodule

// File: rtl/rtmr_channel.sv
module rtmr_channel
  import rtmr_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          tick_en,
  input  logic          evt_a,
  input  logic          evt_b,
  input  logic          emerg_n,
  output logic          uflow,
  output logic          oflow,
  output logic          pulse_out,
  output logic          pulse_oe
);

  logic          start_q;
  logic          cut_en_q;
  rtmr_cfg_t     cfg_q;
  logic [CW-1:0] reload_q;
  logic          ld_stop;
  logic [CW-1:0] cnt_q;
  logic          step;
  logic          ev_uflow;
  logic          ev_oflow;
  logic          wrap;

  rtmr_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_q     (cnt_q),
    .ev_uflow  (ev_uflow),
    .ev_oflow  (ev_oflow),
    .start_q   (start_q),
    .cut_en_q  (cut_en_q),
    .cfg_q     (cfg_q),
    .reload_q  (reload_q),
    .ld_stop   (ld_stop),
    .bus_rdata (bus_rdata)
  );

  rtmr_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_q),
    .cfg      (cfg_q),
    .reload   (reload_q),
    .ld_stop  (ld_stop),
    .ld_val   (bus_wdata),
    .tick_en  (tick_en),
    .evt_a    (evt_a),
    .evt_b    (evt_b),
    .cnt_q    (cnt_q),
    .step     (step),
    .ev_uflow (ev_uflow),
    .ev_oflow (ev_oflow),
    .uflow_q  (uflow),
    .oflow_q  (oflow)
  );

  assign wrap = ev_uflow || ev_oflow;

  rtmr_outctl u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap    (wrap),
    .cut_en  (cut_en_q),
    .emerg_n (emerg_n),
    .pulse_q (pulse_out),
    .oe      (pulse_oe)
  );

endmodule

// File: rtl/rtmr_checker.sv
module rtmr_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_q,
  input logic          cut_en_q,
  input logic [2:0]    cfg_q,
  input logic          ld_stop,
  input logic [CW-1:0] cnt_q,
  input logic          ev_uflow,
  input logic          ev_oflow,
  input logic          bus_rd,
  input logic [1:0]    bus_addr,
  input logic [CW-1:0] bus_rdata,
  input logic          uflow,
  input logic          oflow,
  input logic          pulse_out,
  input logic          pulse_oe,
  input logic          emerg_n
);

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_q) |-> $stable(cfg_q)); // R2

  AST_UFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_uflow |=> uflow); // R4

  AST_UFLOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_uflow && bus_rd && bus_addr == 2'd2) |-> (bus_rdata == '1)); // R4

  AST_OFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_oflow |=> oflow); // R5

  AST_OFLOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_oflow && bus_rd && bus_addr == 2'd2) |-> (bus_rdata == '0)); // R5

  AST_PULSE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_uflow || ev_oflow) |=> (pulse_out != $past(pulse_out))); // R8

  AST_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_en_q && !emerg_n) |-> !pulse_oe); // R9

  AST_NO_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cut_en_q |-> pulse_oe); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_q && !ld_stop) |=> $stable(cnt_q)); // R10

  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0)); // R12

endmodule

bind rtmr_channel rtmr_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_q   (start_q),
  .cut_en_q  (cut_en_q),
  .cfg_q     (cfg_q),
  .ld_stop   (ld_stop),
  .cnt_q     (cnt_q),
  .ev_uflow  (ev_uflow),
  .ev_oflow  (ev_oflow),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .uflow     (uflow),
  .oflow     (oflow),
  .pulse_out (pulse_out),
  .pulse_oe  (pulse_oe),
  .emerg_n   (emerg_n)
);

// File: tb/sim_rtmr_channel.sv
`timescale 1ns/1ps
module sim_rtmr_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        evt_a = 1'b0;
  logic        evt_b = 1'b0;
  logic        emerg_n = 1'b1;
  logic        uflow, oflow, pulse_out, pulse_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtmr_channel u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .evt_a(evt_a), .evt_b(evt_b), .emerg_n(emerg_n),
    .uflow(uflow), .oflow(oflow), .pulse_out(pulse_out), .pulse_oe(pulse_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus write, occupying one rising edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  // combinational read, no edge consumed
  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // strobe: 0 tick, 1 evt_a, 2 evt_b; optional read of count in the same cycle
  task automatic strobe(input int which, input bit with_rd, output logic [15:0] d);
    @(negedge clk);
    tick_en = (which == 0); evt_a = (which == 1); evt_b = (which == 2);
    bus_rd = with_rd; bus_addr = 2'd2;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    tick_en = 1'b0; evt_a = 1'b0; evt_b = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd2, v); check("R1 count", v, 16'h0);
    rd(2'd0, v); check("R1 ctrl", v, 16'h0);
    rd(2'd1, v); check("R1 mode", v, 16'h0);
    check("R1 uflow", {15'd0, uflow}, 16'd0);
    check("R1 oflow", {15'd0, oflow}, 16'd0);
    check("R1 pulse_out", {15'd0, pulse_out}, 16'd0);
    check("R1 pulse_oe", {15'd0, pulse_oe}, 16'd1);
    check("R12 rdata idle", bus_rdata, 16'h0);
  endtask

  task automatic t_timer();
    logic [15:0] v;
    wr(2'd2, 16'd3);
    rd(2'd2, v); check("R7 readback stopped", v, 16'd3);
    wr(2'd1, 16'h0002);                 // timer mode, up bit set (must be ignored)
    wr(2'd0, 16'h0001);
    rd(2'd0, v); check("R11 ctrl readback", v, 16'h0001);
    strobe(1, 1'b0, v); strobe(2, 1'b0, v);
    rd(2'd2, v); check("R3 events ignored in timer mode", v, 16'd3);
    strobe(0, 1'b0, v); rd(2'd2, v); check("R3 tick down 1", v, 16'd2);
    strobe(0, 1'b0, v); strobe(0, 1'b0, v);
    rd(2'd2, v); check("R3 tick down to 0", v, 16'd0);
    strobe(0, 1'b1, v); check("R4 read in reload cycle", v, 16'hFFFF);
    check("R4 uflow raised", {15'd0, uflow}, 16'd1);
    check("R8 pulse toggled high", {15'd0, pulse_out}, 16'd1);
    rd(2'd2, v); check("R4 reloaded count", v, 16'd3);
    idle();
    check("R4 uflow one cycle", {15'd0, uflow}, 16'd0);
  endtask

  task automatic t_mode_lock();
    logic [15:0] v;
    wr(2'd1, 16'h0007);
    rd(2'd1, v); check("R2 mode write ignored while running", v, 16'h0002);
    strobe(0, 1'b0, v); rd(2'd2, v); check("R2 still timer mode", v, 16'd2);
  endtask

  task automatic t_stopped();
    logic [15:0] v;
    wr(2'd0, 16'h0000);
    strobe(0, 1'b0, v); strobe(1, 1'b0, v); strobe(2, 1'b0, v);
    rd(2'd2, v); check("R10 no count while stopped", v, 16'd2);
  endtask

  task automatic t_event_up();
    logic [15:0] v;
    wr(2'd1, 16'h0007);
    rd(2'd1, v); check("R2 mode write while stopped", v, 16'h0007);
    wr(2'd2, 16'hFFFD);
    wr(2'd0, 16'h0001);
    strobe(1, 1'b0, v); rd(2'd2, v); check("R6 unselected strobe ignored", v, 16'hFFFD);
    strobe(2, 1'b0, v); strobe(2, 1'b0, v);
    rd(2'd2, v); check("R6 selected strobe counts up", v, 16'hFFFF);
    strobe(2, 1'b1, v); check("R5 read in overflow cycle", v, 16'h0000);
    check("R5 oflow raised", {15'd0, oflow}, 16'd1);
    check("R8 pulse toggled low", {15'd0, pulse_out}, 16'd0);
    rd(2'd2, v); check("R5 reloaded after overflow", v, 16'hFFFD);
    idle();
    check("R5 oflow one cycle", {15'd0, oflow}, 16'd0);
  endtask

  task automatic t_event_down();
    logic [15:0] v;
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h0001);
    strobe(2, 1'b0, v); rd(2'd2, v); check("R6 evt_b ignored", v, 16'd1);
    strobe(1, 1'b0, v); rd(2'd2, v); check("R6 evt_a counts down", v, 16'd0);
    wr(2'd2, 16'd5);
    rd(2'd2, v); check("R7 running write leaves count", v, 16'd0);
    strobe(1, 1'b1, v); check("R4 event-mode read at underflow", v, 16'hFFFF);
    check("R4 event uflow", {15'd0, uflow}, 16'd1);
    rd(2'd2, v); check("R7 new reload used at wrap", v, 16'd5);
  endtask

  task automatic t_cutoff();
    logic [15:0] v;
    wr(2'd0, 16'h0000);
    @(negedge clk); emerg_n = 1'b0; #1;
    check("R9 no cutoff when disabled", {15'd0, pulse_oe}, 16'd1);
    wr(2'd0, 16'h0002);
    rd(2'd0, v); check("R11 cutoff enable readback", v, 16'h0002);
    check("R9 cutoff active", {15'd0, pulse_oe}, 16'd0);
    idle(); idle();
    check("R9 cutoff holds", {15'd0, pulse_oe}, 16'd0);
    @(negedge clk); emerg_n = 1'b1; #1;
    check("R9 cutoff released", {15'd0, pulse_oe}, 16'd1);
    check("R12 rdata zero without read", bus_rdata, 16'h0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_timer();
    t_mode_lock();
    t_stopped();
    t_event_up();
    t_event_down();
    t_cutoff();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule